// File: doc/BRIEF.md
# Multi-Class Bus Slave Address Matcher

This block sits between the bit engine of a power-management bus slave and its register path. Each time the bit engine finishes an address byte, the matcher compares the 7-bit address against every address class the device answers to. The classes are:

- a fixed all-device broadcast address;
- a fixed broadcast address that obeys the page register;
- a programmable device address that can be switched off;
- a programmable channel address for each channel;
- a programmable rail address for each channel;
- a fault-reporting address that answers only while the non-volatile store failed to load.

One cycle later, in time for the acknowledge bit, it presents a registered decision. The decision holds a hit flag, a one-hot class code, the effective page and a per-channel select mask. It also carries a flag that marks rail-addressed reads so that the register path can refuse them.

When several classes match the same address, a fixed priority picks exactly one class. All programmable addresses arrive on ports, because the register write path sits outside this block. A programmable address whose bit 7 is set is disabled and never matches.

Top module: `pmb_addr_match`

## Requirements
- R1: While rst_n is low and after its release, match_vld, hit, rail_rd, nvm_stat, class_oh, page_out and chan_sel are all zero until the first address is captured.
- R2: An address captured on a clock edge with addr_valid high produces match_vld high for exactly the following cycle. The decision outputs change only on capture and otherwise keep their last values.
- R3: Address 0x5A always matches with class bit 1 (global). page_out is 0xFF and every chan_sel bit is set.
- R4: Address 0x5B matches with class bit 2 (paged global). page_out equals page_cfg. chan_sel is all ones when page_cfg is 0xFF, has the single bit page_cfg set when page_cfg is below the channel count, and is zero otherwise.
- R5: dev_addr_cfg with bit 7 set (for example 0x80) disables device matching. Otherwise an address equal to its low 7 bits matches with class bit 5 (device), and page_out and chan_sel follow the page rule of R4.
- R6: An address equal to an enabled channel address (bit 7 clear) matches with class bit 3 (channel). chan_sel holds only that channel, and page_out is its index. The lowest index wins if two channels share the address.
- R7: An address equal to one or more enabled rail addresses matches with class bit 4 (rail). chan_sel has a bit set for each matching channel. page_out is that channel's index when only one channel matches, and 0xFF when more than one does.
- R8: Address 0x7C matches with class bit 0 (fault report) only while nvm_bad is high. page_out is then 0xFF and chan_sel is zero. nvm_stat equals nvm_bad delayed by one cycle.
- R9: rail_rd is high only when the captured decision has class rail and rw_in was 1 (read) at capture.
- R10: Class priority, from highest to lowest, is fault report, global, paged global, channel, rail, device. When hit is high exactly one class_oh bit is set.
- R11: An address that matches no class gives hit 0, class_oh 0, page_out 0, chan_sel 0 and rail_rd 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | Address byte complete strobe |
| addr_in | input | AW | Received 7-bit address |
| rw_in | input | 1 | Direction bit of the address byte, 1 = read |
| dev_addr_cfg | input | AW+1 | Device address, bit 7 set disables it |
| page_cfg | input | PW | Current page register |
| chan_addr_cfg | input | NCH*(AW+1) | Channel addresses, one byte per channel, bit 7 disables |
| rail_addr_cfg | input | NCH*(AW+1) | Rail addresses, one byte per channel, bit 7 disables |
| nvm_bad | input | 1 | Non-volatile store failed to initialize |
| match_vld | output | 1 | Decision valid pulse |
| hit | output | 1 | Address accepted |
| class_oh | output | 6 | One-hot class: 0 fault, 1 global, 2 paged global, 3 channel, 4 rail, 5 device |
| page_out | output | PW | Effective page |
| chan_sel | output | NCH | Selected channels |
| rail_rd | output | 1 | Rail address used for a read |
| nvm_stat | output | 1 | Registered non-volatile fault status |

## Verification
The decision outputs and match_vld are due on the first clock edge after the strobe. The bench drives the strobe on a falling edge and compares on the next falling edge, which lies half a cycle after the capturing edge. One cycle later it checks that match_vld has dropped and that page_out and chan_sel have held their values. nvm_stat lags nvm_bad by one edge, and the bench compares it on the falling edge that follows a change of nvm_bad.

// File: rtl/pmb_am_pkg.sv
package pmb_am_pkg;
   localparam int unsigned NCLS    = 6;
   localparam int unsigned CB_NVM  = 0;
   localparam int unsigned CB_GLB  = 1;
   localparam int unsigned CB_PGLB = 2;
   localparam int unsigned CB_CHAN = 3;
   localparam int unsigned CB_RAIL = 4;
   localparam int unsigned CB_DEV  = 5;
endpackage

// File: rtl/pmb_am_slot.sv
// Per-channel comparison of the received address with the channel and rail
// address of one channel. Bit AW of each configured byte disables it.
module pmb_am_slot #(
   parameter int unsigned AW = 7
) (
   input  logic [AW-1:0] addr,
   input  logic [AW:0]   chan_cfg,
   input  logic [AW:0]   rail_cfg,
   output logic          chan_hit,
   output logic          rail_hit
);
   always_comb begin
      chan_hit = !chan_cfg[AW] && (chan_cfg[AW-1:0] == addr);
      rail_hit = !rail_cfg[AW] && (rail_cfg[AW-1:0] == addr);
   end
endmodule

// File: rtl/pmb_am_pagemask.sv
// Converts a page register value into a channel mask: all ones for the
// broadcast page, one bit for an in-range page, nothing otherwise.
module pmb_am_pagemask #(
   parameter int unsigned NCH = 2,
   parameter int unsigned PW  = 8
) (
   input  logic [PW-1:0]  page,
   output logic [NCH-1:0] mask
);
   localparam logic [PW-1:0] PAGE_ALL = '1;

   always_comb begin
      mask = '0;
      if (page == PAGE_ALL) begin
         mask = '1;
      end else begin
         for (int i = 0; i < NCH; i++) begin
            if (page == PW'(i)) mask[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pmb_am_resolve.sv
// Priority resolution between address classes and effective page selection.
module pmb_am_resolve
   import pmb_am_pkg::*;
#(
   parameter int unsigned NCH = 2,
   parameter int unsigned AW  = 7,
   parameter int unsigned PW  = 8,
   parameter logic [AW-1:0] GLB_ADDR  = 7'h5A,
   parameter logic [AW-1:0] PGLB_ADDR = 7'h5B,
   parameter logic [AW-1:0] NVM_ADDR  = 7'h7C
) (
   input  logic [AW-1:0]   addr,
   input  logic [AW:0]     dev_cfg,
   input  logic [PW-1:0]   page_cfg,
   input  logic [NCH-1:0]  page_mask,
   input  logic [NCH-1:0]  chan_hits,
   input  logic [NCH-1:0]  rail_hits,
   input  logic            nvm_bad,
   output logic [NCLS-1:0] cls,
   output logic [PW-1:0]   page,
   output logic [NCH-1:0]  sel
);
   localparam logic [PW-1:0] PAGE_ALL = '1;

   logic nvm_m, glb_m, pglb_m, dev_m;
   logic [PW-1:0]  chan_page;
   logic [NCH-1:0] chan_first;
   logic [PW-1:0]  rail_page;
   int unsigned    rail_cnt;

   always_comb begin
      nvm_m  = nvm_bad && (addr == NVM_ADDR);
      glb_m  = (addr == GLB_ADDR);
      pglb_m = (addr == PGLB_ADDR);
      dev_m  = !dev_cfg[AW] && (dev_cfg[AW-1:0] == addr);
   end

   // Lowest-index channel hit.
   always_comb begin
      logic found;
      found      = 1'b0;
      chan_page  = '0;
      chan_first = '0;
      for (int i = 0; i < NCH; i++) begin
         if (chan_hits[i] && !found) begin
            found         = 1'b1;
            chan_page     = PW'(i);
            chan_first[i] = 1'b1;
         end
      end
   end

   // Rail page: the index of a single hit, otherwise the broadcast page.
   always_comb begin
      rail_cnt  = 0;
      rail_page = '0;
      for (int i = 0; i < NCH; i++) begin
         if (rail_hits[i]) begin
            rail_cnt  = rail_cnt + 1;
            rail_page = PW'(i);
         end
      end
      if (rail_cnt > 1) rail_page = PAGE_ALL;
   end

   always_comb begin
      cls  = '0;
      page = '0;
      sel  = '0;
      if (nvm_m) begin
         cls[CB_NVM] = 1'b1;
         page        = PAGE_ALL;
      end else if (glb_m) begin
         cls[CB_GLB] = 1'b1;
         page        = PAGE_ALL;
         sel         = '1;
      end else if (pglb_m) begin
         cls[CB_PGLB] = 1'b1;
         page         = page_cfg;
         sel          = page_mask;
      end else if (|chan_hits) begin
         cls[CB_CHAN] = 1'b1;
         page         = chan_page;
         sel          = chan_first;
      end else if (|rail_hits) begin
         cls[CB_RAIL] = 1'b1;
         page         = rail_page;
         sel          = rail_hits;
      end else if (dev_m) begin
         cls[CB_DEV] = 1'b1;
         page        = page_cfg;
         sel         = page_mask;
      end
   end
endmodule

// File: rtl/pmb_addr_match.sv
module pmb_addr_match
   import pmb_am_pkg::*;
#(
   parameter int unsigned NCH = 2,
   parameter int unsigned AW  = 7,
   parameter int unsigned PW  = 8,
   parameter logic [AW-1:0] GLB_ADDR  = 7'h5A,
   parameter logic [AW-1:0] PGLB_ADDR = 7'h5B,
   parameter logic [AW-1:0] NVM_ADDR  = 7'h7C
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  addr_valid,
   input  logic [AW-1:0]         addr_in,
   input  logic                  rw_in,
   input  logic [AW:0]           dev_addr_cfg,
   input  logic [PW-1:0]         page_cfg,
   input  logic [NCH*(AW+1)-1:0] chan_addr_cfg,
   input  logic [NCH*(AW+1)-1:0] rail_addr_cfg,
   input  logic                  nvm_bad,
   output logic                  match_vld,
   output logic                  hit,
   output logic [NCLS-1:0]       class_oh,
   output logic [PW-1:0]         page_out,
   output logic [NCH-1:0]        chan_sel,
   output logic                  rail_rd,
   output logic                  nvm_stat
);
   localparam int unsigned CW = AW + 1;

   if (NCH < 1 || NCH >= (1 << PW) - 1) begin : g_bad_nch
      $error("pmb_addr_match: NCH must be at least 1 and below the broadcast page");
   end
   if (AW < 1) begin : g_bad_aw
      $error("pmb_addr_match: AW must be positive");
   end

   logic [NCH-1:0]  chan_hits, rail_hits, page_mask, sel_d;
   logic [NCLS-1:0] cls_d;
   logic [PW-1:0]   page_d;

   for (genvar g = 0; g < NCH; g++) begin : g_slot
      pmb_am_slot #(.AW(AW)) u_slot (
         .addr     (addr_in),
         .chan_cfg (chan_addr_cfg[g*CW +: CW]),
         .rail_cfg (rail_addr_cfg[g*CW +: CW]),
         .chan_hit (chan_hits[g]),
         .rail_hit (rail_hits[g])
      );
   end

   pmb_am_pagemask #(.NCH(NCH), .PW(PW)) u_pmask (
      .page (page_cfg),
      .mask (page_mask)
   );

   pmb_am_resolve #(
      .NCH(NCH), .AW(AW), .PW(PW),
      .GLB_ADDR(GLB_ADDR), .PGLB_ADDR(PGLB_ADDR), .NVM_ADDR(NVM_ADDR)
   ) u_res (
      .addr      (addr_in),
      .dev_cfg   (dev_addr_cfg),
      .page_cfg  (page_cfg),
      .page_mask (page_mask),
      .chan_hits (chan_hits),
      .rail_hits (rail_hits),
      .nvm_bad   (nvm_bad),
      .cls       (cls_d),
      .page      (page_d),
      .sel       (sel_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_vld <= 1'b0;
         hit       <= 1'b0;
         class_oh  <= '0;
         page_out  <= '0;
         chan_sel  <= '0;
         rail_rd   <= 1'b0;
         nvm_stat  <= 1'b0;
      end else begin
         match_vld <= addr_valid;
         nvm_stat  <= nvm_bad;
         if (addr_valid) begin
            hit      <= |cls_d;
            class_oh <= cls_d;
            page_out <= page_d;
            chan_sel <= sel_d;
            rail_rd  <= cls_d[CB_RAIL] && rw_in;
         end
      end
   end
endmodule

// File: rtl/pmb_am_chk.sv
module pmb_am_chk
   import pmb_am_pkg::*;
#(
   parameter int unsigned NCH = 2,
   parameter int unsigned AW  = 7,
   parameter int unsigned PW  = 8,
   parameter logic [AW-1:0] GLB_ADDR  = 7'h5A,
   parameter logic [AW-1:0] PGLB_ADDR = 7'h5B,
   parameter logic [AW-1:0] NVM_ADDR  = 7'h7C
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  addr_valid,
   input logic [AW-1:0]         addr_in,
   input logic                  rw_in,
   input logic [AW:0]           dev_addr_cfg,
   input logic [PW-1:0]         page_cfg,
   input logic [NCH*(AW+1)-1:0] chan_addr_cfg,
   input logic [NCH*(AW+1)-1:0] rail_addr_cfg,
   input logic                  nvm_bad,
   input logic                  match_vld,
   input logic                  hit,
   input logic [NCLS-1:0]       class_oh,
   input logic [PW-1:0]         page_out,
   input logic [NCH-1:0]        chan_sel,
   input logic                  rail_rd,
   input logic                  nvm_stat
);
   p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |=> match_vld);
   p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_valid |=> !match_vld);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_valid |=> $stable(page_out) && $stable(chan_sel) && $stable(class_oh));
   p_global_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && addr_in == GLB_ADDR && !(nvm_bad && addr_in == NVM_ADDR))
      |=> hit && class_oh[CB_GLB] && (&page_out) && (&chan_sel));
   p_nvm_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && !nvm_bad) |=> !class_oh[CB_NVM]);
   p_nvm_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      nvm_bad |=> nvm_stat);
   p_rail_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rail_rd |-> class_oh[CB_RAIL]);
   p_one_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
      match_vld |-> ($countones(class_oh) == (hit ? 1 : 0)));
   p_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (match_vld && !hit) |-> (chan_sel == '0 && page_out == '0 && !rail_rd));
endmodule

bind pmb_addr_match pmb_am_chk #(
   .NCH(NCH), .AW(AW), .PW(PW),
   .GLB_ADDR(GLB_ADDR), .PGLB_ADDR(PGLB_ADDR), .NVM_ADDR(NVM_ADDR)
) u_chk (.*);

// File: tb/sim_pmb_addr_match.sv
module sim_pmb_addr_match;
   localparam int NCH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_valid = 1'b0;
   logic [6:0]  addr_in = '0;
   logic        rw_in = 1'b0;
   logic [7:0]  dev_addr_cfg = 8'h80;
   logic [7:0]  page_cfg = 8'h00;
   logic [15:0] chan_addr_cfg = 16'h8080;
   logic [15:0] rail_addr_cfg = 16'h8080;
   logic        nvm_bad = 1'b0;
   logic        match_vld, hit, rail_rd, nvm_stat;
   logic [5:0]  class_oh;
   logic [7:0]  page_out;
   logic [1:0]  chan_sel;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic       e_hit, e_rd;
   logic [5:0] e_cls;
   logic [7:0] e_page;
   logic [1:0] e_sel;

   always #10 clk = ~clk;

   pmb_addr_match u0 (.*);

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [1:0] pmask(input logic [7:0] p);
      if (p == 8'hFF) return 2'b11;
      if (p == 8'd0)  return 2'b01;
      if (p == 8'd1)  return 2'b10;
      return 2'b00;
   endfunction

   // Reference decision built from the requirements (R3..R11).
   task automatic expect_for(input logic [6:0] a, input logic rw);
      logic [1:0] ch, rl;
      ch[0] = !chan_addr_cfg[7]  && chan_addr_cfg[6:0]  == a;
      ch[1] = !chan_addr_cfg[15] && chan_addr_cfg[14:8] == a;
      rl[0] = !rail_addr_cfg[7]  && rail_addr_cfg[6:0]  == a;
      rl[1] = !rail_addr_cfg[15] && rail_addr_cfg[14:8] == a;
      e_cls = '0; e_page = '0; e_sel = '0;
      if (nvm_bad && a == 7'h7C) begin
         e_cls = 6'b000001; e_page = 8'hFF;
      end else if (a == 7'h5A) begin
         e_cls = 6'b000010; e_page = 8'hFF; e_sel = 2'b11;
      end else if (a == 7'h5B) begin
         e_cls = 6'b000100; e_page = page_cfg; e_sel = pmask(page_cfg);
      end else if (ch != 0) begin
         e_cls = 6'b001000;
         e_page = ch[0] ? 8'd0 : 8'd1;
         e_sel = ch[0] ? 2'b01 : 2'b10;
      end else if (rl != 0) begin
         e_cls = 6'b010000;
         e_sel = rl;
         e_page = (rl == 2'b11) ? 8'hFF : (rl[0] ? 8'd0 : 8'd1);
      end else if (!dev_addr_cfg[7] && dev_addr_cfg[6:0] == a) begin
         e_cls = 6'b100000; e_page = page_cfg; e_sel = pmask(page_cfg);
      end
      e_hit = (e_cls != 0);
      e_rd  = e_cls[4] && rw;
   endtask

   task automatic send(input logic [6:0] a, input logic rw, input string req);
      logic [7:0] pg; logic [1:0] sl;
      expect_for(a, rw);
      addr_in = a; rw_in = rw; addr_valid = 1'b1;
      @(negedge clk);
      addr_valid = 1'b0;
      chk("R2", {req, " vld"}, match_vld, 1);
      chk(req, "hit", hit, e_hit);
      chk(req, "class", class_oh, e_cls);
      chk(req, "page", page_out, e_page);
      chk(req, "sel", chan_sel, e_sel);
      chk(req, "rail_rd", rail_rd, e_rd);
      pg = page_out; sl = chan_sel;
      addr_in = ~a;
      @(negedge clk);
      chk("R2", "vld drop", match_vld, 0);
      chk("R2", "hold", {page_out, chan_sel}, {pg, sl});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual expired expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "outs", {match_vld, hit, rail_rd, nvm_stat, class_oh, page_out, chan_sel}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "after release", {match_vld, hit, class_oh, page_out, chan_sel}, 0);

      // Directed corner cases
      page_cfg = 8'd1;
      send(7'h5A, 0, "R3");
      send(7'h5B, 0, "R4");
      page_cfg = 8'hFF; send(7'h5B, 0, "R4");
      page_cfg = 8'd7;  send(7'h5B, 0, "R4");
      dev_addr_cfg = 8'h80; send(7'h00, 0, "R5");
      dev_addr_cfg = 8'h80; send(7'h00, 0, "R11");
      dev_addr_cfg = 8'h30; page_cfg = 8'd0; send(7'h30, 0, "R5");
      chan_addr_cfg = {8'h41, 8'h40}; send(7'h41, 0, "R6");
      chan_addr_cfg = {8'h42, 8'h42}; send(7'h42, 0, "R6");
      chan_addr_cfg = {8'hC1, 8'h80}; send(7'h41, 0, "R6");
      rail_addr_cfg = {8'h20, 8'h20}; send(7'h20, 0, "R7");
      send(7'h20, 1, "R9");
      rail_addr_cfg = {8'h21, 8'h20}; send(7'h21, 1, "R7");
      nvm_bad = 1'b0; send(7'h7C, 0, "R8");
      nvm_bad = 1'b1;
      @(negedge clk);
      chk("R8", "nvm_stat", nvm_stat, 1);
      send(7'h7C, 1, "R8");
      // Priority: channel and rail and device on one address
      chan_addr_cfg = {8'h80, 8'h33}; rail_addr_cfg = {8'h33, 8'h33}; dev_addr_cfg = 8'h33;
      send(7'h33, 1, "R10");
      chan_addr_cfg = 16'h8080; send(7'h33, 0, "R10");
      rail_addr_cfg = 16'h8080; send(7'h33, 0, "R10");
      dev_addr_cfg = 8'h5A; send(7'h5A, 0, "R10");
      nvm_bad = 1'b0;
      @(negedge clk);
      chk("R8", "nvm_stat low", nvm_stat, 0);

      // Constrained random mix
      for (int k = 0; k < 400; k++) begin
         logic [6:0] a;
         logic [2:0] pick;
         logic [6:0] pool [6];
         pool[0] = 7'h5A; pool[1] = 7'h5B; pool[2] = 7'h7C;
         pool[3] = 7'($urandom_range(0, 7)) | 7'h10;
         pool[4] = 7'($urandom_range(0, 7)) | 7'h10;
         pool[5] = 7'($urandom);
         if (k % 16 == 0) begin
            dev_addr_cfg  = ($urandom_range(0, 3) == 0) ? 8'h80 : {1'b0, 7'h10 | 7'($urandom_range(0, 7))};
            chan_addr_cfg = {($urandom_range(0, 3) == 0) ? 8'h80 : {1'b0, 7'h10 | 7'($urandom_range(0, 7))},
                             ($urandom_range(0, 3) == 0) ? 8'h80 : {1'b0, 7'h10 | 7'($urandom_range(0, 7))}};
            rail_addr_cfg = {($urandom_range(0, 3) == 0) ? 8'h80 : {1'b0, 7'h10 | 7'($urandom_range(0, 7))},
                             ($urandom_range(0, 3) == 0) ? 8'h80 : {1'b0, 7'h10 | 7'($urandom_range(0, 7))}};
            case ($urandom_range(0, 3))
               0: page_cfg = 8'd0;
               1: page_cfg = 8'd1;
               2: page_cfg = 8'hFF;
               default: page_cfg = 8'($urandom_range(2, 254));
            endcase
            nvm_bad = ($urandom_range(0, 1) == 1);
            @(negedge clk);
            chk("R8", "nvm_stat rnd", nvm_stat, nvm_bad);
         end
         pick = 3'($urandom_range(0, 5));
         a = pool[pick];
         send(a, 1'($urandom_range(0, 1)), "R10");
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule